// File: doc/BRIEF.md
# Programmable-Period Watchdog Timer

This block is a watchdog with a small word-wide register interface. Software picks two period codes, one for the first count after the watchdog starts and one for every later count. It then sets the start bit. From then on a down-counter falls by one on every clock. Software must write a fixed key value to the restart register before the counter reaches zero. If the count runs out, the block raises a reset-request output for a fixed number of cycles and starts the next count on its own. Once the watchdog is running, software has no way to stop it. Only the hardware reset input returns it to the idle state.

Each 4-bit period code `i` selects a count of `2^(BASE_SHIFT+i)` cycles. `BASE_SHIFT` is a parameter with a default of 16, so codes 0 to 15 span 2^16 to 2^31 cycles. Registers sit at byte offsets within a 16-byte window, and the upper address bits must be zero.

Top module: `wdog_timer`

## Requirements
- R1: After `rst_n` is released, every register reads 0 and `wd_rst_req` is low. While the watchdog is not running, the count stays at 0.
- R2: The period register at offset 0x04 holds the running-period code in bits 3:0 and the first-period code in bits 7:4. Bits above 7 are discarded on write and read as 0.
- R3: A write to offset 0x00 with bit 0 set starts the watchdog. Bit 0 of 0x00 then reads 1, and on that same clock edge the counter loads `2^(BASE_SHIFT + first-period code)`.
- R4: Once started, the watchdog cannot be stopped by software. Writing 0 to offset 0x00 leaves bit 0 reading 1, and the counter keeps falling.
- R5: While running, the counter falls by exactly one per clock. Offset 0x08 returns its live value.
- R6: While running, writing exactly 0x00000076 to offset 0x0C reloads the counter with `2^(BASE_SHIFT + running-period code)`, not with the first-period value.
- R7: These writes leave the counter unchanged: any other value written to 0x0C, any write to 0x08, and a key write made while the watchdog is stopped.
- R8: When the running counter is seen at 0 on a clock edge, `wd_rst_req` is high for exactly 8 cycles, starting in the next cycle. On that same edge the counter reloads from the running-period code.
- R9: A key write that lands on the same edge where the counter is seen at 0 does not prevent the reset request. A key write one edge earlier does prevent it.
- R10: Reads of offset 0x0C and of offsets with no register return 0. Writes to offsets with no register change nothing.
- R11: Asserting `rst_n` in the middle of a run returns the block to the state of R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from address |
| wd_rst_req | output | 1 | Reset request, high for PULSE_LEN cycles on timeout |

## Verification
The two functions that can meet in one cycle are the restart by key and the timeout at zero. The bench counts edges from a known reload so that a key write lands exactly on the edge that sees the count at zero. It expects the reset request to be high in the following cycle anyway. A second run places the key one edge earlier and expects no request and a fresh count. The bench also overrides `BASE_SHIFT` to 4 so that whole timeouts fit in a short run.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int CODE_W    = 4;
  localparam int NUM_CODES = 1 << CODE_W;

  // byte offsets inside the 16-byte register window
  localparam logic [3:0] OFS_CTRL  = 4'h0;
  localparam logic [3:0] OFS_RANGE = 4'h4;
  localparam logic [3:0] OFS_COUNT = 4'h8;
  localparam logic [3:0] OFS_KICK  = 4'hC;

  localparam logic [7:0] KICK_KEY  = 8'h76;

  typedef enum logic [2:0] {
    RS_NONE,
    RS_CTRL,
    RS_RANGE,
    RS_COUNT,
    RS_KICK
  } reg_sel_e;

  // first-period code sits in the upper nibble
  typedef struct packed {
    logic [CODE_W-1:0] init_code;
    logic [CODE_W-1:0] top_code;
  } range_t;

endpackage

// File: rtl/wdog_period.sv
module wdog_period
  import wdog_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int BASE_SHIFT = 16
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [CNT_W-1:0]  period_o
);

  logic [CNT_W-1:0] tbl [NUM_CODES];

  for (genvar g = 0; g < NUM_CODES; g++) begin : g_tbl
    assign tbl[g] = CNT_W'(1) << (BASE_SHIFT + g);
  end

  assign period_o = tbl[code_i];

endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              en_o,
  output logic [CODE_W-1:0] top_code_o,
  output logic [CODE_W-1:0] init_code_o,
  output logic              start_o,
  output logic              kick_o,
  output logic [DATA_W-1:0] bus_rdata
);

  localparam int RANGE_W = 2 * CODE_W;

  reg_sel_e rsel;
  logic     wr_stb;
  logic     en_q, en_d, en_ce;
  range_t   range_q, range_d;
  logic     range_ce;

  // address decode: upper address bits must be clear
  always_comb begin
    rsel = RS_NONE;
    if (bus_addr[ADDR_W-1:4] == '0) begin
      case (bus_addr[3:0])
        OFS_CTRL:  rsel = RS_CTRL;
        OFS_RANGE: rsel = RS_RANGE;
        OFS_COUNT: rsel = RS_COUNT;
        OFS_KICK:  rsel = RS_KICK;
        default:   rsel = RS_NONE;
      endcase
    end
  end

  assign wr_stb = bus_sel & bus_wr;

  // enable: set-only
  always_comb begin
    en_ce = wr_stb && (rsel == RS_CTRL) && bus_wdata[0] && !en_q;
    en_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else if (en_ce) begin
      en_q <= en_d;
    end
  end

  // period codes
  always_comb begin
    range_ce = wr_stb && (rsel == RS_RANGE);
    range_d  = range_t'(bus_wdata[RANGE_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      range_q <= '0;
    end else if (range_ce) begin
      range_q <= range_d;
    end
  end

  assign en_o        = en_q;
  assign top_code_o  = range_q.top_code;
  assign init_code_o = range_q.init_code;
  assign start_o     = en_ce;
  assign kick_o      = wr_stb && (rsel == RS_KICK) && en_q &&
                       (bus_wdata == DATA_W'(KICK_KEY));

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (rsel)
        RS_CTRL:  bus_rdata = DATA_W'(en_q);
        RS_RANGE: bus_rdata = DATA_W'(range_q);
        RS_COUNT: bus_rdata = DATA_W'(cnt_i);
        default:  bus_rdata = '0;
      endcase
    end
  end

  // R4: enable never falls without hardware reset
  p_sticky_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> en_q);

  // R2: a period write is captured intact
  p_range_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    range_ce |=> (range_q == $past(range_d)));

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W     = 32,
  parameter int PULSE_LEN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             start_i,
  input  logic             kick_i,
  input  logic [CNT_W-1:0] top_val_i,
  input  logic [CNT_W-1:0] init_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             rst_req_o
);

  localparam int PW = $clog2(PULSE_LEN + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PW-1:0]    pulse_q, pulse_d;
  logic             expire;
  logic             cnt_ce, pulse_ce;

  assign expire = en_i && (cnt_q == '0);

  // counter next state; expiry and key both reload the running period
  always_comb begin
    cnt_d  = cnt_q;
    cnt_ce = 1'b0;
    if (start_i) begin
      cnt_d  = init_val_i;
      cnt_ce = 1'b1;
    end else if (en_i) begin
      cnt_ce = 1'b1;
      if (expire || kick_i) begin
        cnt_d = top_val_i;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  // reset-request stretcher
  always_comb begin
    pulse_d  = pulse_q;
    pulse_ce = 1'b0;
    if (expire) begin
      pulse_d  = PW'(PULSE_LEN);
      pulse_ce = 1'b1;
    end else if (pulse_q != '0) begin
      pulse_d  = pulse_q - PW'(1);
      pulse_ce = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= '0;
    end else if (pulse_ce) begin
      pulse_q <= pulse_d;
    end
  end

  assign cnt_o     = cnt_q;
  assign rst_req_o = (pulse_q != '0);

  // R5: plain countdown
  p_countdown_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !kick_i && !start_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  // R6: key reloads the running period
  p_kick_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && kick_i && cnt_q != '0) |=> (cnt_q == $past(top_val_i)));

  // R3: first load takes the first-period value
  p_first_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (cnt_q == $past(init_val_i)));

  // R8: zero raises the request and reloads
  p_expire_r8: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (rst_req_o && cnt_q == $past(top_val_i)));

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 32,
  parameter int BASE_SHIFT = 16,
  parameter int PULSE_LEN  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wd_rst_req
);

  logic              en;
  logic              start;
  logic              kick;
  logic [CODE_W-1:0] top_code;
  logic [CODE_W-1:0] init_code;
  logic [CNT_W-1:0]  top_val;
  logic [CNT_W-1:0]  init_val;
  logic [CNT_W-1:0]  cnt;

  wdog_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .cnt_i       (cnt),
    .en_o        (en),
    .top_code_o  (top_code),
    .init_code_o (init_code),
    .start_o     (start),
    .kick_o      (kick),
    .bus_rdata   (bus_rdata)
  );

  wdog_period #(
    .CNT_W      (CNT_W),
    .BASE_SHIFT (BASE_SHIFT)
  ) u_top_period (
    .code_i   (top_code),
    .period_o (top_val)
  );

  wdog_period #(
    .CNT_W      (CNT_W),
    .BASE_SHIFT (BASE_SHIFT)
  ) u_init_period (
    .code_i   (init_code),
    .period_o (init_val)
  );

  wdog_counter #(
    .CNT_W     (CNT_W),
    .PULSE_LEN (PULSE_LEN)
  ) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en),
    .start_i    (start),
    .kick_i     (kick),
    .top_val_i  (top_val),
    .init_val_i (init_val),
    .cnt_o      (cnt),
    .rst_req_o  (wd_rst_req)
  );

  // R1: a stopped watchdog holds a zero count and no request
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (cnt == '0 && !wd_rst_req));

endmodule

// File: tb/wdog_timer_tb.sv
module wdog_timer_tb;

  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  logic              clk;
  logic              rst_n;
  logic              bus_sel;
  logic              bus_wr;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata;
  logic [DATA_W-1:0] bus_rdata;
  logic              wd_rst_req;

  int checks = 0;
  int errors = 0;

  wdog_timer #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .CNT_W      (32),
    .BASE_SHIFT (4),
    .PULSE_LEN  (8)
  ) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .wd_rst_req (wd_rst_req)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // two edges pass; the second one captures the write
  task automatic wr_reg(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  // one edge passes before the sample
  task automatic rd_reg(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state(input string tag);
    logic [31:0] v;
    rd_reg(12'h000, v); chk({tag, " ctrl"}, v, 0);
    rd_reg(12'h004, v); chk({tag, " range"}, v, 0);
    rd_reg(12'h008, v); chk({tag, " count"}, v, 0);
    chk({tag, " rst_req"}, {31'b0, wd_rst_req}, 0);
  endtask

  task automatic t_kick_stopped();
    logic [31:0] v;
    wr_reg(12'h00C, 32'h76);
    rd_reg(12'h008, v); chk("R7 key while stopped, count", v, 0);
    rd_reg(12'h000, v); chk("R7 key while stopped, ctrl", v, 0);
  endtask

  task automatic t_range_and_holes();
    logic [31:0] v;
    wr_reg(12'h004, 32'hFFFF_FF21);
    rd_reg(12'h004, v); chk("R2 period codes readback", v, 32'h21);
    wr_reg(12'h006, 32'hAB);
    wr_reg(12'h104, 32'hCD);
    rd_reg(12'h004, v); chk("R10 hole writes ignored", v, 32'h21);
    rd_reg(12'h00C, v); chk("R10 restart reads zero", v, 0);
    rd_reg(12'h002, v); chk("R10 hole reads zero", v, 0);
  endtask

  // init code 2 -> 64, running code 1 -> 32 (BASE_SHIFT=4)
  task automatic t_enable_and_sticky();
    logic [31:0] v;
    wr_reg(12'h000, 32'h1);                                 // edge E, count 64
    rd_reg(12'h008, v); chk("R3 first load from first-period code", v, 63);
    rd_reg(12'h008, v); chk("R5 one per clock", v, 62);
    rd_reg(12'h000, v); chk("R3 enable reads 1", v, 1);     // E+3
    wr_reg(12'h000, 32'h0);                                 // E+5
    rd_reg(12'h000, v); chk("R4 enable sticky", v, 1);      // E+6
    rd_reg(12'h008, v); chk("R4 count keeps running", v, 57);
    wr_reg(12'h00C, 32'h75);                                // E+9
    wr_reg(12'h008, 32'h5);                                 // E+11
    rd_reg(12'h008, v); chk("R7 wrong key and count write ignored", v, 52);
    wr_reg(12'h00C, 32'h76);
    rd_reg(12'h008, v); chk("R6 key reloads running period", v, 31);
  endtask

  task automatic t_expire();
    logic [31:0] v;
    int n, h;
    wr_reg(12'h00C, 32'h76);                                // edge K, count 32
    n = 0;
    while (!wd_rst_req && n < 200) begin @(negedge clk); n++; end
    chk("R8 request after count runs out", n, 33);
    h = 0;
    while (wd_rst_req && h < 50) begin h++; @(negedge clk); end
    chk("R8 request length", h, 8);
    rd_reg(12'h008, v); chk("R8 reload from running code", v, 23);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    wr_reg(12'h00C, 32'h76);                                // K2
    repeat (31) @(negedge clk);
    wr_reg(12'h00C, 32'h76);                                // captured at K2+33, count 0
    chk("R9 key at zero still requests", {31'b0, wd_rst_req}, 1);
    rd_reg(12'h008, v); chk("R9 count after collision", v, 31);
    repeat (12) @(negedge clk);
    chk("R9 request ended", {31'b0, wd_rst_req}, 0);
    wr_reg(12'h00C, 32'h76);                                // K3
    repeat (30) @(negedge clk);
    wr_reg(12'h00C, 32'h76);                                // captured at K3+32, count 1
    rd_reg(12'h008, v); chk("R9 early key reloads", v, 31);
    chk("R9 early key avoids request", {31'b0, wd_rst_req}, 0);
  endtask

  task automatic t_hw_reset();
    logic [31:0] v;
    int n;
    do_reset();
    t_reset_state("R11");
    wr_reg(12'h004, 32'h03);                                // init 0 -> 16, running 3 -> 128
    wr_reg(12'h000, 32'h1);                                 // E, count 16
    rd_reg(12'h008, v); chk("R3 first-period code 0", v, 15);
    n = 0;
    while (!wd_rst_req && n < 200) begin @(negedge clk); n++; end
    chk("R8 first timeout uses first period", n, 16);
    rd_reg(12'h008, v); chk("R8 later period from running code", v, 127);
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    do_reset();
    t_reset_state("R1");
    t_kick_stopped();
    t_range_and_holes();
    t_enable_and_sticky();
    t_expire();
    t_collide();
    t_hw_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule